// File: doc/BRIEF.md
# Voltage Control Mode Manager

This block decides which of three control modes a regulator channel runs in: bus-controlled, adaptive-voltage (AVS), or the AVS-startup sub-mode. The channel only chooses between bus control and AVS on a power-on event. At that point it samples the stored enable and startup bits. Once the channel is in an AVS mode, a live copy of the startup bit moves it into and out of the startup sub-mode at runtime.

The block also enforces the register access rules that depend on the mode. It takes decoded write and read requests with a command code and answers, in the same cycle, with accept, reject or NACK. A rejected write sets a sticky communication error flag and raises an alert. Both stay up until a clear-status pulse arrives. Commands from the AVS interface are passed on only while the channel is in plain AVS mode.

Top module: `vmode_mgr`

## Requirements
- R1: After reset the mode is bus-controlled (code 0), and the error flag and alert are both low.
- R2: On a cycle with `por_strobe` high, the mode one cycle later depends on the stored bits. Enable=0 gives bus mode (code 0). Enable=1 with startup=0 gives AVS (code 1). Enable=1 with startup=1 gives AVS-startup (code 2).
- R3: Changing `nv_enable` has no effect on the mode unless `por_strobe` is high.
- R4: Without a power-on event, the live startup bit changes the mode one cycle later. In AVS with `live_startup`=1 the mode becomes AVS-startup. In AVS-startup with `live_startup`=0 the mode becomes AVS.
- R5: In bus mode without a power-on event the mode stays bus, whatever `live_startup` is.
- R6: Writes to the four protected configuration codes (E9h..ECh) behave by mode. In AVS and AVS-startup they give `wr_reject`=1 and `wr_accept`=0 in the same cycle. In bus mode they are accepted.
- R7: The setpoint code EAh (the second protected code) is accepted in AVS-startup mode and rejected in AVS mode.
- R8: In AVS and AVS-startup, any read or write to codes D4h, D5h or D6h gives `nack`=1 and is neither accepted nor rejected. In bus mode `nack` stays 0.
- R9: A rejected write sets `cml_other` and `alert` one cycle later. Both hold until cleared.
- R10: A `clr_status` pulse clears `cml_other` and `alert` one cycle later. A rejected write in the same cycle wins, and the flag stays set.
- R11: `avs_cmd_accept` follows `avs_cmd_valid` in the same cycle only in AVS mode. It is 0 in bus and AVS-startup modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| por_strobe | input | 1 | Power-on event; samples the stored bits |
| nv_enable | input | 1 | Stored AVS enable bit |
| nv_startup | input | 1 | Stored startup sub-mode bit |
| live_startup | input | 1 | Runtime copy of the startup bit |
| wr_req | input | 1 | Decoded write request |
| rd_req | input | 1 | Decoded read request |
| cmd_code | input | 8 | Command code of the request |
| avs_cmd_valid | input | 1 | Command arriving on the AVS interface |
| clr_status | input | 1 | Clear pulse for the error flag |
| mode | output | 2 | Current mode: 0 bus, 1 AVS, 2 AVS-startup |
| wr_accept | output | 1 | Write is allowed to take effect |
| wr_reject | output | 1 | Write dropped because the register is read-only |
| nack | output | 1 | Request refused on the bus |
| avs_cmd_accept | output | 1 | AVS command is passed on |
| cml_other | output | 1 | Sticky communication error flag |
| alert | output | 1 | Alert output, high while the flag is set |

## Verification
The access decisions (`wr_accept`, `wr_reject`, `nack`, `avs_cmd_accept`) are combinational and due in the same cycle as the request. Mode changes, error-flag sets and clears are due one clock edge after the inputs that cause them. The bench drives inputs just after a falling edge and compares shortly afterwards. At that point the same-cycle decisions are compared against the model's current state, and registered results are compared against the state the model advanced at the previous rising edge. Sequences cover every power-on combination, the runtime sub-mode moves, protected and NACKed codes in each mode, and a set that collides with a clear.

// File: rtl/vmode_pkg.sv
package vmode_pkg;

  typedef enum logic [1:0] {
    MODE_BUS   = 2'd0,
    MODE_AVS   = 2'd1,
    MODE_START = 2'd2
  } vmode_e;

  // Mode chosen from the stored bits on a power-on event.
  function automatic vmode_e por_mode(input logic en, input logic st);
    if (!en)     return MODE_BUS;
    else if (st) return MODE_START;
    else         return MODE_AVS;
  endfunction

  // Runtime move driven by the live startup bit; bus mode never moves.
  function automatic vmode_e live_mode(input vmode_e cur, input logic live);
    case (cur)
      MODE_AVS:   return live ? MODE_START : MODE_AVS;
      MODE_START: return live ? MODE_START : MODE_AVS;
      default:    return MODE_BUS;
    endcase
  endfunction

  function automatic logic avs_active(input vmode_e m);
    return (m == MODE_AVS) || (m == MODE_START);
  endfunction

endpackage

// File: rtl/vmode_fsm.sv
module vmode_fsm
  import vmode_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   por_strobe,
  input  logic   nv_enable,
  input  logic   nv_startup,
  input  logic   live_startup,
  output vmode_e mode_q
);

  vmode_e mode_d;
  logic   enter_start_ev;
  logic   leave_start_ev;

  assign enter_start_ev = !por_strobe && (mode_q == MODE_AVS) && live_startup;
  assign leave_start_ev = !por_strobe && (mode_q == MODE_START) && !live_startup;

  always_comb begin
    if (por_strobe) mode_d = por_mode(nv_enable, nv_startup);
    else            mode_d = live_mode(mode_q, live_startup);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_BUS;
    else        mode_q <= mode_d;
  end

  a_r5_bus_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_BUS && !por_strobe) |=> (mode_q == MODE_BUS));
  a_r2_por_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (por_strobe && !nv_enable) |=> (mode_q == MODE_BUS));
  a_r4_enter_start: assert property (@(posedge clk) disable iff (!rst_n)
    enter_start_ev |=> (mode_q == MODE_START));
  a_r4_leave_start: assert property (@(posedge clk) disable iff (!rst_n)
    leave_start_ev |=> (mode_q == MODE_AVS));

endmodule

// File: rtl/vmode_access.sv
module vmode_access
  import vmode_pkg::*;
#(
  parameter int                CODE_W        = 8,
  parameter logic [CODE_W-1:0] AVS_REG_BASE  = 8'hE9,
  parameter int                AVS_REG_COUNT = 4,
  parameter int                SETPOINT_OFS  = 1,
  parameter logic [CODE_W-1:0] NACK_BASE     = 8'hD4,
  parameter int                NACK_COUNT    = 3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  vmode_e            mode,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              avs_cmd_valid,
  output logic              wr_accept,
  output logic              wr_reject,
  output logic              nack,
  output logic              avs_cmd_accept
);

  localparam logic [CODE_W-1:0] SETPOINT_CODE = AVS_REG_BASE + CODE_W'(SETPOINT_OFS);

  logic [AVS_REG_COUNT-1:0] prot_hit;
  logic [NACK_COUNT-1:0]    nack_hit;
  logic                     prot_any;
  logic                     nack_any;
  logic                     setpoint_open;
  logic                     in_avs;

  for (genvar g = 0; g < AVS_REG_COUNT; g++) begin : g_prot
    localparam logic [CODE_W-1:0] THIS_CODE = AVS_REG_BASE + CODE_W'(g);
    assign prot_hit[g] = (cmd_code == THIS_CODE);
  end

  for (genvar g = 0; g < NACK_COUNT; g++) begin : g_nack
    localparam logic [CODE_W-1:0] THIS_CODE = NACK_BASE + CODE_W'(g);
    assign nack_hit[g] = (cmd_code == THIS_CODE);
  end

  assign prot_any      = |prot_hit;
  assign nack_any      = |nack_hit;
  assign in_avs        = avs_active(mode);
  assign setpoint_open = (mode == MODE_START) && (cmd_code == SETPOINT_CODE);

  always_comb begin
    nack           = in_avs && nack_any && (wr_req || rd_req);
    wr_reject      = wr_req && in_avs && prot_any && !setpoint_open && !nack;
    wr_accept      = wr_req && !wr_reject && !nack;
    avs_cmd_accept = avs_cmd_valid && (mode == MODE_AVS);
  end

  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_accept && wr_reject));
  a_r8_bus_no_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BUS) |-> !nack);
  a_r7_setpoint_open: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_START && wr_req && cmd_code == SETPOINT_CODE) |-> wr_accept);
  a_r11_start_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_START) |-> !avs_cmd_accept);

endmodule

// File: rtl/vmode_status.sv
module vmode_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_status,
  output logic cml_other,
  output logic alert
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (set_ev)     flag_q <= 1'b1;
    else if (clr_status) flag_q <= 1'b0;
  end

  assign cml_other = flag_q;
  assign alert     = flag_q;

  a_r9_set_after_reject: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> cml_other);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cml_other && !clr_status) |=> cml_other);
  a_r10_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_status && !set_ev) |=> !cml_other);

endmodule

// File: rtl/vmode_mgr.sv
module vmode_mgr
  import vmode_pkg::*;
#(
  parameter int                CODE_W        = 8,
  parameter logic [CODE_W-1:0] AVS_REG_BASE  = 8'hE9,
  parameter int                AVS_REG_COUNT = 4,
  parameter int                SETPOINT_OFS  = 1,
  parameter logic [CODE_W-1:0] NACK_BASE     = 8'hD4,
  parameter int                NACK_COUNT    = 3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_strobe,
  input  logic              nv_enable,
  input  logic              nv_startup,
  input  logic              live_startup,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              avs_cmd_valid,
  input  logic              clr_status,
  output logic [1:0]        mode,
  output logic              wr_accept,
  output logic              wr_reject,
  output logic              nack,
  output logic              avs_cmd_accept,
  output logic              cml_other,
  output logic              alert
);

  vmode_e mode_cur;
  logic   reject_ev;

  vmode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .por_strobe   (por_strobe),
    .nv_enable    (nv_enable),
    .nv_startup   (nv_startup),
    .live_startup (live_startup),
    .mode_q       (mode_cur)
  );

  vmode_access #(
    .CODE_W        (CODE_W),
    .AVS_REG_BASE  (AVS_REG_BASE),
    .AVS_REG_COUNT (AVS_REG_COUNT),
    .SETPOINT_OFS  (SETPOINT_OFS),
    .NACK_BASE     (NACK_BASE),
    .NACK_COUNT    (NACK_COUNT)
  ) u_access (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode           (mode_cur),
    .wr_req         (wr_req),
    .rd_req         (rd_req),
    .cmd_code       (cmd_code),
    .avs_cmd_valid  (avs_cmd_valid),
    .wr_accept      (wr_accept),
    .wr_reject      (reject_ev),
    .nack           (nack),
    .avs_cmd_accept (avs_cmd_accept)
  );

  vmode_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_ev     (reject_ev),
    .clr_status (clr_status),
    .cml_other  (cml_other),
    .alert      (alert)
  );

  assign mode      = mode_cur;
  assign wr_reject = reject_ev;

  a_r1_legal_mode: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);
  a_r3_no_por_no_bus_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_strobe && mode != 2'd0) |=> (mode != 2'd0));

endmodule

// File: tb/vmode_mgr_tb.sv
`timescale 1ns/1ps
module vmode_mgr_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       por_strobe, nv_enable, nv_startup, live_startup;
  logic       wr_req, rd_req, avs_cmd_valid, clr_status;
  logic [7:0] cmd_code;
  logic [1:0] mode;
  logic       wr_accept, wr_reject, nack, avs_cmd_accept, cml_other, alert;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference state
  int m_mode;
  bit m_flag;

  always #2 clk = ~clk;

  vmode_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .por_strobe(por_strobe), .nv_enable(nv_enable),
    .nv_startup(nv_startup), .live_startup(live_startup), .wr_req(wr_req),
    .rd_req(rd_req), .cmd_code(cmd_code), .avs_cmd_valid(avs_cmd_valid),
    .clr_status(clr_status), .mode(mode), .wr_accept(wr_accept),
    .wr_reject(wr_reject), .nack(nack), .avs_cmd_accept(avs_cmd_accept),
    .cml_other(cml_other), .alert(alert)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    por_strobe = 0; wr_req = 0; rd_req = 0; cmd_code = 8'h00;
    avs_cmd_valid = 0; clr_status = 0;
  endtask

  // One clock: compare, advance the model at the rising edge, return after the falling edge.
  task automatic cyc(input string tag);
    bit in_avs, prot, np, e_nack, e_rej, e_acc, e_avs;
    #1;
    in_avs = (m_mode == 1) || (m_mode == 2);
    prot   = (cmd_code >= 8'hE9) && (cmd_code <= 8'hEC);
    np     = (cmd_code >= 8'hD4) && (cmd_code <= 8'hD6);
    e_nack = in_avs && np && (wr_req || rd_req);
    e_rej  = wr_req && in_avs && prot && !e_nack && !(m_mode == 2 && cmd_code == 8'hEA);
    e_acc  = wr_req && !e_rej && !e_nack;
    e_avs  = avs_cmd_valid && (m_mode == 1);
    cmp(tag, "mode", int'(mode), m_mode);
    cmp(tag, "wr_accept", int'(wr_accept), int'(e_acc));
    cmp(tag, "wr_reject", int'(wr_reject), int'(e_rej));
    cmp(tag, "nack", int'(nack), int'(e_nack));
    cmp(tag, "avs_cmd_accept", int'(avs_cmd_accept), int'(e_avs));
    cmp(tag, "cml_other", int'(cml_other), int'(m_flag));
    cmp(tag, "alert", int'(alert), int'(m_flag));
    @(posedge clk);
    if (por_strobe) m_mode = !nv_enable ? 0 : (nv_startup ? 2 : 1);
    else if (m_mode == 1 && live_startup) m_mode = 2;
    else if (m_mode == 2 && !live_startup) m_mode = 1;
    if (e_rej) m_flag = 1;
    else if (clr_status) m_flag = 0;
    @(negedge clk);
  endtask

  task automatic wr(input string tag, input logic [7:0] c);
    idle(); wr_req = 1; cmd_code = c; cyc(tag);
  endtask

  task automatic rd(input string tag, input logic [7:0] c);
    idle(); rd_req = 1; cmd_code = c; cyc(tag);
  endtask

  task automatic por(input string tag, input bit en, input bit st);
    idle(); nv_enable = en; nv_startup = st; por_strobe = 1; cyc(tag);
    idle(); cyc(tag);
  endtask

  initial begin
    #(4 * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; nv_enable = 0; nv_startup = 0; live_startup = 0; idle();
    m_mode = 0; m_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cyc("R1");
    // R6 R8 bus mode: protected writes accepted, no NACK
    for (int c = 8'hE9; c <= 8'hEC; c++) wr("R6", 8'(c));
    rd("R8", 8'hD4); wr("R8", 8'hD6);
    // R5 live bit ignored in bus mode; R11 AVS commands ignored
    idle(); live_startup = 1; avs_cmd_valid = 1; cyc("R5"); cyc("R11");
    live_startup = 0;
    // R3 stored enable without power-on
    idle(); nv_enable = 1; cyc("R3"); cyc("R3");
    // R2 power-on into AVS
    por("R2", 1, 0);
    idle(); avs_cmd_valid = 1; cyc("R11");
    // R6 R7 rejected writes, R9 flag sticky
    wr("R7", 8'hEA);
    idle(); cyc("R9"); cyc("R9"); cyc("R9");
    idle(); clr_status = 1; cyc("R10");
    idle(); cyc("R10");
    wr("R6", 8'hEC);
    rd("R8", 8'hD5); wr("R8", 8'hD4); rd("R8", 8'hE9);
    // R10 set beats clear
    idle(); wr_req = 1; cmd_code = 8'hE9; clr_status = 1; cyc("R10");
    idle(); cyc("R10"); clr_status = 1; cyc("R10"); idle(); cyc("R10");
    // R3 stored enable cleared, still AVS
    nv_enable = 0; cyc("R3"); cyc("R3");
    // R4 enter startup at runtime
    idle(); live_startup = 1; cyc("R4"); cyc("R4");
    wr("R7", 8'hEA); wr("R6", 8'hEB);
    idle(); avs_cmd_valid = 1; cyc("R11");
    rd("R8", 8'hD6);
    idle(); clr_status = 1; cyc("R10");
    // R4 leave startup
    idle(); live_startup = 0; cyc("R4"); cyc("R4");
    // R2 power-on into startup, then into bus
    live_startup = 1;
    por("R2", 1, 1);
    wr("R7", 8'hEA);
    live_startup = 0;
    por("R2", 0, 1);
    idle(); live_startup = 1; cyc("R5"); cyc("R5");
    live_startup = 0;
    por("R2", 1, 0);
    por("R2", 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule